// File: doc/BRIEF.md
# Timestamped PTP Receive Frame Ring

This block captures incoming Ethernet frames that an upstream stage has already classified as precision-time-protocol traffic. It stores them in a ring of sixteen fixed-size slots of 256 bytes each. Frames arrive one byte per cycle, with start and end markers. The block samples a 64-bit seconds/nanoseconds time input on the first byte of each frame. When the frame ends, it files that time stamp into the last eight bytes of the slot.

A single control/status word tells software which slot was completed last. Software keeps its own read index and drains slots until its index catches up. The block raises a level interrupt whenever a frame has been committed, and software clears it by writing a one to bit 0 of the control word. The hardware never learns where the reader is, so a slow reader simply loses the oldest slots.

Slot contents and the control word are read through a simple 32-bit register port with one cycle of read latency. Because frames are stored byte-exact, the message type of a stored frame can be found at slot byte 14 (word 3, bits 19:16 hold its low nibble).

Top module: `ptp_rx_ring`

## Requirements
- R1: After reset the control word (byte address 0x1000) reads 0, which means index 0 and nothing pending, and `irq` is low.
- R2: Each completed frame (end marker accepted) is written to slot (index+1) mod 16. The write index in control bits 11:8 advances by exactly one on the cycle the end marker is taken, and never at any other time.
- R3: Frame byte k lands at slot byte offset k. Slot byte offset k is read from 32-bit word k/4, in bits 8*(k%4)+7 : 8*(k%4). Unused byte lanes of a frame's final word read as zero.
- R4: Frame bytes at positions 248 and above are dropped, so the time stamp area of the slot is never overwritten by frame data.
- R5: The seconds value present on the start-of-frame cycle is readable at slot byte 248, and the nanoseconds value from that same cycle is readable at slot byte 252.
- R6: `irq` and control bit 0 go high in the same cycle in which the write index advances, and they stay high until cleared.
- R7: Writing a word with bit 0 set to address 0x1000 clears the pending flag, and writing a zero in bit 0 leaves it set. If a frame completes in the same cycle as a clear, the flag stays set.
- R8: After sixteen frames the index wraps back to 0, and the seventeenth frame overwrites slot 1 with its own data and stamp.
- R9: Bytes that arrive with no frame open are ignored. A start marker inside an open frame abandons the partial frame, and that abandoned frame does not advance the index.
- R10: Register writes to slot addresses have no effect on stored contents. Every read returns its data on `reg_rdata` one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| time_sec | input | 32 | Current time, seconds |
| time_ns | input | 32 | Current time, nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address: slots below 0x1000, control word at 0x1000 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Frame-stored interrupt (level) |

## Verification
The bench sends a sweep of frame lengths: every length from one to eight bytes, lengths on either side of a word boundary, and lengths just below, at and beyond the 248-byte limit. After each frame it reads back every stored word and both stamp words. The short lengths separate correct byte-lane placement and zero fill from off-by-one packing. The long lengths show whether truncation protects the stamp area. Seventeen frames in a row show the index wrapping and slot 1 being reused. Separate patterns cover stray bytes, an abandoned partial frame, a clear that coincides with a frame end, a write of zero, and writes aimed at slot addresses, which tell apart a correct flag and index from one that reacts to the wrong event.

// File: rtl/prr_pkg.sv
package prr_pkg;

  typedef enum logic [1:0] {
    RD_MEM  = 2'd0,
    RD_SEC  = 2'd1,
    RD_NS   = 2'd2,
    RD_CTRL = 2'd3
  } rd_src_e;

  // Place one byte into a 32-bit word at the given lane (little-endian).
  function automatic logic [31:0] put_lane(input logic [31:0] word,
                                           input logic [1:0]  lane,
                                           input logic [7:0]  data);
    logic [31:0] r;
    r = word;
    r[8*lane +: 8] = data;
    return r;
  endfunction

  // Pack the status word: index field starts at bit 8, pending at bit 0.
  function automatic logic [31:0] ctrl_pack(input logic [7:0] idx8,
                                            input logic       pend);
    return {16'd0, idx8, 7'd0, pend};
  endfunction

endpackage

// File: rtl/prr_packer.sv
module prr_packer #(
  parameter int unsigned SLOT_AW    = 8,
  parameter int unsigned DATA_LIMIT = 248
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_sof,
  input  logic                 in_eof,
  output logic                 wr_en,
  output logic [SLOT_AW-3:0]   wr_word,
  output logic [31:0]          wr_data,
  output logic                 frame_start,
  output logic                 frame_done
);
  import prr_pkg::*;

  logic               in_frame;
  logic [SLOT_AW-1:0] cnt;
  logic [31:0]        acc;

  logic               active;
  logic               keep;
  logic [SLOT_AW-1:0] pos;
  logic [31:0]        merged;

  always_comb begin
    frame_start = in_valid & in_sof;
    active      = in_valid & (in_sof | in_frame);
    pos         = frame_start ? '0 : cnt;
    keep        = active & (pos < SLOT_AW'(DATA_LIMIT));
    merged      = put_lane(frame_start ? 32'd0 : acc, pos[1:0], in_data);
    wr_en       = keep & ((pos[1:0] == 2'd3) | in_eof);
    wr_word     = pos[SLOT_AW-1:2];
    wr_data     = merged;
    frame_done  = active & in_eof;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
    end else if (active) begin
      in_frame <= ~in_eof;
      cnt      <= keep ? pos + 1'b1 : pos;
      if (wr_en || in_eof) acc <= '0;
      else if (keep)       acc <= merged;
    end
  end

endmodule

// File: rtl/prr_store.sv
module prr_store #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/prr_stamp_bank.sv
module prr_stamp_bank #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic [IDX_W-1:0] slot,
  input  logic [31:0]      sec_in,
  input  logic [31:0]      ns_in,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [31:0]      rd_sec,
  output logic [31:0]      rd_ns
);
  localparam int unsigned N = 1 << IDX_W;

  logic [31:0] cap_sec, cap_ns;
  logic [31:0] sec_q [N];
  logic [31:0] ns_q  [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sec <= '0;
      cap_ns  <= '0;
    end else if (start) begin
      cap_sec <= sec_in;
      cap_ns  <= ns_in;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sec_q[i] <= '0;
        ns_q[i]  <= '0;
      end else if (done && slot == IDX_W'(i)) begin
        sec_q[i] <= start ? sec_in : cap_sec;
        ns_q[i]  <= start ? ns_in  : cap_ns;
      end
    end
  end

  assign rd_sec = sec_q[rd_slot];
  assign rd_ns  = ns_q[rd_slot];

endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             clr,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic             pending
);
  assign next_idx = wr_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      pending <= 1'b0;
    end else begin
      if (done) wr_idx <= next_idx;
      if (done)     pending <= 1'b1;
      else if (clr) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/ptp_rx_ring.sv
module ptp_rx_ring #(
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SLOT_AW     = 8,
  parameter int unsigned STAMP_BYTES = 8,
  parameter int unsigned ADDR_W      = IDX_W + SLOT_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [31:0]       time_sec,
  input  logic [31:0]       time_ns,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import prr_pkg::*;

  localparam int unsigned WORD_AW    = SLOT_AW - 2;
  localparam int unsigned DATA_LIMIT = (1 << SLOT_AW) - STAMP_BYTES;
  localparam int unsigned SEC_WORD   = DATA_LIMIT / 4;
  localparam int unsigned NS_WORD    = SEC_WORD + 1;
  localparam int unsigned MEM_AW     = IDX_W + WORD_AW;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  // Named internal events (also observed by the bound checker)
  logic               wr_en;
  logic [WORD_AW-1:0] wr_word;
  logic [31:0]        wr_data;
  logic               frame_start;
  logic               frame_done;
  logic [IDX_W-1:0]   wr_idx, next_idx;
  logic               pending;
  logic               clr;

  prr_packer #(.SLOT_AW(SLOT_AW), .DATA_LIMIT(DATA_LIMIT)) u_packer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .frame_start(frame_start), .frame_done(frame_done)
  );

  assign clr = reg_wr & (reg_addr == CTRL_ADDR) & reg_wdata[0];

  prr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .clr(clr),
    .wr_idx(wr_idx), .next_idx(next_idx), .pending(pending)
  );

  // Read decode
  logic                rd_ctrl;
  logic [IDX_W-1:0]    rd_slot;
  logic [WORD_AW-1:0]  rd_word;
  rd_src_e             rd_src, src_q;
  logic [31:0]         st_sec, st_ns, aux_q, mem_q;

  always_comb begin
    rd_ctrl = reg_addr[ADDR_W-1];
    rd_slot = reg_addr[IDX_W+SLOT_AW-1:SLOT_AW];
    rd_word = reg_addr[SLOT_AW-1:2];
    if (rd_ctrl)                            rd_src = RD_CTRL;
    else if (rd_word == WORD_AW'(SEC_WORD)) rd_src = RD_SEC;
    else if (rd_word == WORD_AW'(NS_WORD))  rd_src = RD_NS;
    else                                    rd_src = RD_MEM;
  end

  prr_stamp_bank #(.IDX_W(IDX_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .done(frame_done),
    .slot(next_idx), .sec_in(time_sec), .ns_in(time_ns),
    .rd_slot(rd_slot), .rd_sec(st_sec), .rd_ns(st_ns)
  );

  prr_store #(.AW(MEM_AW)) u_store (
    .clk(clk),
    .we(wr_en), .waddr({next_idx, wr_word}), .wdata(wr_data),
    .re(reg_rd & (rd_src == RD_MEM)), .raddr({rd_slot, rd_word}),
    .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= RD_CTRL;
      aux_q <= '0;
    end else if (reg_rd) begin
      src_q <= rd_src;
      unique case (rd_src)
        RD_SEC:  aux_q <= st_sec;
        RD_NS:   aux_q <= st_ns;
        RD_CTRL: aux_q <= ctrl_pack(8'(wr_idx), pending);
        default: aux_q <= '0;
      endcase
    end
  end

  assign reg_rdata = (src_q == RD_MEM) ? mem_q : aux_q;
  assign irq       = pending;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:1], reg_addr[1:0]};

endmodule

// File: rtl/prr_checker.sv
module prr_checker #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned WORD_AW  = 6,
  parameter int unsigned SEC_WORD = 62
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_done,
  input logic               wr_en,
  input logic [WORD_AW-1:0] wr_word,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               pending,
  input logic               clr
);

  a_r2_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> wr_idx == IDX_W'($past(wr_idx) + 1'b1));

  a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(wr_idx));

  a_r4_stamp_area_safe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_word < WORD_AW'(SEC_WORD));

  a_r6_irq_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(frame_done));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !frame_done) |=> !pending);

  a_r7_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> pending);

endmodule

bind ptp_rx_ring prr_checker #(
  .IDX_W(IDX_W), .WORD_AW(WORD_AW), .SEC_WORD(SEC_WORD)
) u_prr_checker (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .wr_en(wr_en),
  .wr_word(wr_word), .wr_idx(wr_idx), .pending(pending), .clr(clr)
);

// File: tb/ptp_rx_ring_tb.sv
module ptp_rx_ring_tb;

  localparam logic [12:0] CTRL = 13'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [31:0] time_sec = '0, time_ns = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  ptp_rx_ring u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .time_sec(time_sec), .time_ns(time_ns),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] fbyte(int seed, int k);
    return 8'((seed * 13 + k * 7 + (k >> 3)) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(int len, int seed, logic [31:0] sec, logic [31:0] ns,
                      bit clr_last);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fbyte(seed, k);
      in_sof = (k == 0); in_eof = (k == len - 1);
      time_sec = (k == 0) ? sec : ~sec;
      time_ns  = (k == 0) ? ns  : ns + 32'(k) + 32'd5000;
      if (clr_last && k == len - 1) begin
        reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 32'h1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; reg_wr = 1'b0;
    exp_idx = (exp_idx + 1) % 16;
  endtask

  task automatic verify_slot(int slot, int len, int seed,
                             logic [31:0] sec, logic [31:0] ns);
    int kept = (len < 248) ? len : 248;
    logic [31:0] d;
    for (int w = 0; w < (kept + 3) / 4; w++) begin
      logic [31:0] e = '0;
      for (int l = 0; l < 4; l++)
        if (4 * w + l < kept) e[8*l +: 8] = fbyte(seed, 4 * w + l);
      rd(13'(slot * 256 + w * 4), d);
      check((len > 248) ? "R4 truncated data" : "R3 byte placement", d, e);
    end
    rd(13'(slot * 256 + 248), d);
    check("R5 R4 stamp seconds", d, sec);
    rd(13'(slot * 256 + 252), d);
    check("R5 R4 stamp nanoseconds", d, ns);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lens[17] = '{1, 2, 3, 4, 5, 6, 7, 8, 15, 16, 17, 60, 247, 248, 249, 252, 300};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(CTRL, d);
    check("R1 ctrl after reset", d, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    // Length sweep across 17 frames: wraps the ring (R2, R8)
    for (int i = 0; i < 17; i++) begin
      logic [31:0] sec = 32'(100 + i);
      logic [31:0] ns  = 32'(1000 * i + 7);
      send(lens[i], i + 3, sec, ns, 1'b0);
      check("R6 irq after frame", 32'(irq), 32'h1);
      rd(CTRL, d);
      check("R2 R6 ctrl index and pending", d, 32'((exp_idx << 8) | 1));
      if (i == 15) check("R8 index wraps to 0", 32'(d[11:8]), 32'h0);
      verify_slot(exp_idx, lens[i], i + 3, sec, ns);
      if (i == 16) check("R8 overwrite went to slot 1", 32'(exp_idx), 32'h1);
      if (i == 2) begin
        wr(CTRL, 32'h0);
        rd(CTRL, d);
        check("R7 write of zero keeps pending", d, 32'((exp_idx << 8) | 1));
      end
      wr(CTRL, 32'h1);
      rd(CTRL, d);
      check("R7 clear pending", d, 32'(exp_idx << 8));
      check("R7 irq low after clear", 32'(irq), 32'h0);
    end

    // R7 clear in the same cycle as a frame end
    send(9, 40, 32'hA5A5_0001, 32'h0000_1234, 1'b1);
    rd(CTRL, d);
    check("R7 commit wins over clear", d, 32'((exp_idx << 8) | 1));
    verify_slot(exp_idx, 9, 40, 32'hA5A5_0001, 32'h0000_1234);
    wr(CTRL, 32'h1);

    // R9 stray bytes with no frame open
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(k); in_sof = 1'b0; in_eof = (k == 9);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    rd(CTRL, d);
    check("R9 stray bytes ignored", d, 32'(exp_idx << 8));

    // R9 abandoned partial frame, then a full one
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hEE; in_sof = (k == 0); in_eof = 1'b0;
      time_sec = 32'hDEAD; time_ns = 32'hBEEF;
    end
    rd(CTRL, d);
    check("R9 partial frame no advance", d, 32'(exp_idx << 8));
    send(12, 77, 32'h0000_0777, 32'h0000_0888, 1'b0);
    rd(CTRL, d);
    check("R9 restart advances once", d, 32'((exp_idx << 8) | 1));
    verify_slot(exp_idx, 12, 77, 32'h0000_0777, 32'h0000_0888);

    // R10 writes into slot space have no effect
    wr(13'(exp_idx * 256), 32'hDEAD_BEEF);
    wr(13'(exp_idx * 256 + 252), 32'hCAFE_F00D);
    rd(13'(exp_idx * 256), d);
    check("R10 slot word unchanged", d,
          {fbyte(77, 3), fbyte(77, 2), fbyte(77, 1), fbyte(77, 0)});
    rd(13'(exp_idx * 256 + 252), d);
    check("R10 stamp unchanged", d, 32'h0000_0888);
    rd(CTRL, d);
    check("R10 ctrl unchanged by slot writes", d, 32'((exp_idx << 8) | 1));

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule